// File: doc/BRIEF.md
# Edge-Selectable Multi-Line Wake-Up Controller

This block watches a parallel group of asynchronous input lines and turns a chosen transition on any armed line into a latched event. Each line has three bits of control state: an arm bit, a polarity bit that picks which transition counts, and a latched-event bit. A latched event on an armed line drives a level wake request. The system's power manager uses that request to leave the halt or idle low-power state.

The same latched events can also raise one shared interrupt request. This path is built only when the `HAS_IRQ` parameter is set, and it is gated by a run-time enable bit. Software reaches all state through a small register port with one write path and one combinational read path.

Latched-event bits come up cleared after reset. Software is still expected to clear them before arming lines, so that no stale event survives. When software changes the polarity of an armed line, that change can itself create an event. The safe order is to disarm the line, change its polarity, and then re-arm it.

Top module: `mwk_wakeup`

## Requirements
- R1: After reset, the arm (select 0), polarity (select 1), latched-event (select 2) and control (select 3) registers all read zero, and `wake_o` and `irq_o` are low.
- R2: With polarity bit 0, a low-to-high change on an armed line sets that line's latched-event bit. The bit reads as set on the third rising clock edge after the pin changes and not before.
- R3: With polarity bit 1, a high-to-low change on an armed line sets that line's latched-event bit, with the same three-edge latency.
- R4: A transition opposite to the selected polarity leaves the latched-event bit unchanged.
- R5: Transitions on a line whose arm bit is 0 never set its latched-event bit.
- R6: `wake_o` is high exactly when some line has both its arm bit and its latched-event bit set. Clearing an arm bit drops the request but keeps the latched bit.
- R7: A write to select 2 loads the written value into the latched-event register, so writing 0 clears bits. An event that arrives in the same cycle as the write still leaves its bit set.
- R8: Changing the polarity bit of an armed line whose pin is steady sets that line's latched-event bit one edge after the write when the adjusted level goes from 0 to 1. This happens, for example, when a low pin has its polarity changed from 0 to 1.
- R9: `irq_o` equals `wake_o` AND control bit 0 (select 3), and it is held low when `HAS_IRQ` is 0.
- R10: Lines are independent. Simultaneous transitions on several lines set exactly the bits of the lines whose selected edge occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_LINES | Asynchronous monitored lines |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Write register select (0 arm, 1 polarity, 2 latched, 3 control) |
| reg_wdata | input | NUM_LINES | Write data |
| reg_rsel | input | 2 | Read register select, same encoding |
| reg_rdata | output | NUM_LINES | Read data of the selected register |
| wake_o | output | 1 | Wake request |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench builds the block with eight lines, a two-stage synchroniser and the interrupt variant present. This makes the exact three-edge latency from pin to latched bit observable, and it lets the control bit be checked gating the interrupt against the wake request. With eight lines, mixed per-line polarities and simultaneous transitions can be applied, including the polarity-change side effect. The timing of a clearing write can be placed so that it collides with an incoming event.

// File: rtl/mwk_pkg.sv
package mwk_pkg;
   localparam int SEL_W = 2;
   typedef enum logic [SEL_W-1:0] {
      SEL_ARM  = 2'd0,
      SEL_POL  = 2'd1,
      SEL_LAT  = 2'd2,
      SEL_CTRL = 2'd3
   } mwk_sel_e;
endpackage

// File: rtl/mwk_sync.sv
module mwk_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mwk_edge.sv
module mwk_edge #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   input  logic [WIDTH-1:0] fall_i,
   output logic [WIDTH-1:0] evt_o
);
   logic [WIDTH-1:0] adj;
   logic [WIDTH-1:0] adj_q;

   // polarity folded into the level: a selected edge is always a 0->1 step
   assign adj = lvl_i ^ fall_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) adj_q <= '0;
      else        adj_q <= adj;
   end

   assign evt_o = adj & ~adj_q;

   // R2 R3 R8: an event needs a change of level or of polarity since the last edge
   evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o != '0) |-> ((lvl_i != $past(lvl_i)) || (fall_i != $past(fall_i))));
endmodule

// File: rtl/mwk_regs.sv
module mwk_regs
   import mwk_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit HAS_IRQ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [SEL_W-1:0] wsel_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [SEL_W-1:0] rsel_i,
   input  logic [WIDTH-1:0] evt_i,
   output logic [WIDTH-1:0] arm_o,
   output logic [WIDTH-1:0] fall_o,
   output logic [WIDTH-1:0] lat_o,
   output logic             irq_en_o,
   output logic [WIDTH-1:0] rdata_o
);
   logic             wr_arm, wr_pol, wr_lat, wr_ctrl;
   logic [WIDTH-1:0] set_v;
   logic [WIDTH-1:0] lat_n;

   assign wr_arm  = we_i && (wsel_i == SEL_ARM);
   assign wr_pol  = we_i && (wsel_i == SEL_POL);
   assign wr_lat  = we_i && (wsel_i == SEL_LAT);
   assign wr_ctrl = we_i && (wsel_i == SEL_CTRL);

   assign set_v = evt_i & arm_o;
   assign lat_n = (wr_lat ? wdata_i : lat_o) | set_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_o  <= '0;
         fall_o <= '0;
         lat_o  <= '0;
      end else begin
         if (wr_arm) arm_o  <= wdata_i;
         if (wr_pol) fall_o <= wdata_i;
         lat_o <= lat_n;
      end
   end

   if (HAS_IRQ) begin : g_ctrl
      logic ie_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ie_q <= 1'b0;
         else if (wr_ctrl) ie_q <= wdata_i[0];
      end
      assign irq_en_o = ie_q;
   end else begin : g_no_ctrl
      assign irq_en_o = 1'b0;
   end

   always_comb begin
      rdata_o = '0;
      unique case (rsel_i)
         SEL_ARM:  rdata_o = arm_o;
         SEL_POL:  rdata_o = fall_o;
         SEL_LAT:  rdata_o = lat_o;
         SEL_CTRL: rdata_o[0] = irq_en_o;
         default:  rdata_o = '0;
      endcase
   end

   // R5: a disarmed line's bit only appears through a software write
   disarmed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lat_o & ~$past(lat_o) & ~$past(arm_o)) != '0) |-> $past(wr_lat));

   // R7: a load takes the written value except where an armed event arrived
   lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_lat) |-> (((lat_o ^ $past(wdata_i)) & ~$past(evt_i & arm_o)) == '0));
endmodule

// File: rtl/mwk_wakeup.sv
module mwk_wakeup
   import mwk_pkg::*;
#(
   parameter int NUM_LINES   = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_IRQ     = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_i,
   input  logic                 reg_we,
   input  logic [1:0]           reg_wsel,
   input  logic [NUM_LINES-1:0] reg_wdata,
   input  logic [1:0]           reg_rsel,
   output logic [NUM_LINES-1:0] reg_rdata,
   output logic                 wake_o,
   output logic                 irq_o
);
   if (NUM_LINES < 1 || NUM_LINES > 32) begin : g_bad_lines
      $error("mwk_wakeup: NUM_LINES out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mwk_wakeup: SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] lvl_s;
   logic [NUM_LINES-1:0] evt;
   logic [NUM_LINES-1:0] arm, fall, lat;
   logic                 irq_en;

   mwk_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl_s));

   mwk_edge #(.WIDTH(NUM_LINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_s), .fall_i(fall), .evt_o(evt));

   mwk_regs #(.WIDTH(NUM_LINES), .HAS_IRQ(HAS_IRQ)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we), .wsel_i(reg_wsel),
      .wdata_i(reg_wdata), .rsel_i(reg_rsel), .evt_i(evt),
      .arm_o(arm), .fall_o(fall), .lat_o(lat), .irq_en_o(irq_en),
      .rdata_o(reg_rdata));

   assign wake_o = |(arm & lat);

   if (HAS_IRQ) begin : g_irq
      assign irq_o = wake_o & irq_en;
   end else begin : g_no_irq
      assign irq_o = 1'b0;
   end

   // R6: a new wake request follows an edge event or a register write
   wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_o) |-> ($past(evt != '0) || $past(reg_we)));

   // R9: the interrupt is never raised without a wake request
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (wake_o && ($past(wake_o) || $past(evt != '0) || $past(reg_we))));
endmodule

// File: tb/mwk_wakeup_bench.sv
module mwk_wakeup_bench;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin_i = '0;
   logic         reg_we = 1'b0;
   logic [1:0]   reg_wsel = '0;
   logic [N-1:0] reg_wdata = '0;
   logic [1:0]   reg_rsel = '0;
   logic [N-1:0] reg_rdata;
   logic         wake_o, irq_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   typedef struct packed {
      logic [1:0]   sel;
      logic [N-1:0] data;
      logic         wake;
      logic         irq;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   mwk_wakeup #(.NUM_LINES(N), .SYNC_STAGES(2), .HAS_IRQ(1'b1)) u_mwk_wakeup (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
      .reg_wsel(reg_wsel), .reg_wdata(reg_wdata), .reg_rsel(reg_rsel),
      .reg_rdata(reg_rdata), .wake_o(wake_o), .irq_o(irq_o));

   // monitor: pops one expectation per falling edge and compares
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() != 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            reg_rsel = e.sel;
            #1;
            checks++;
            if (reg_rdata !== e.data || wake_o !== e.wake || irq_o !== e.irq) begin
               errors++;
               $display("FAIL %s: sel=%0d data=%h wake=%b irq=%b expected data=%h wake=%b irq=%b",
                        t, e.sel, reg_rdata, wake_o, irq_o, e.data, e.wake, e.irq);
            end
         end
      end
   end

   task automatic expect_st(input string t, input logic [1:0] s, input logic [N-1:0] d,
                            input logic w, input logic i);
      exp_t e;
      e.sel = s; e.data = d; e.wake = w; e.irq = i;
      exp_q.push_back(e);
      tag_q.push_back(t);
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] s, input logic [N-1:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_wsel = s; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic set_pins(input logic [N-1:0] v);
      @(posedge clk); #1;
      pin_i = v;
   endtask

   task automatic edges(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      #1;
   endtask

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, cycles=%0d expected below 100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      expect_st("R1", 2'd0, 8'h00, 1'b0, 1'b0);
      expect_st("R1", 2'd1, 8'h00, 1'b0, 1'b0);
      expect_st("R1", 2'd2, 8'h00, 1'b0, 1'b0);
      expect_st("R1", 2'd3, 8'h00, 1'b0, 1'b0);

      // polarity first while disarmed, then arm: no spurious event
      wr(2'd1, 8'h0A);
      wr(2'd0, 8'h0F);
      edges(2);
      expect_st("R8", 2'd2, 8'h00, 1'b0, 1'b0);

      // R2 rising edge on line 0, latency
      set_pins(8'h01);
      edges(2);
      expect_st("R2", 2'd2, 8'h00, 1'b0, 1'b0);
      edges(0);
      expect_st("R2", 2'd2, 8'h01, 1'b1, 1'b0);

      // R4 opposite edges
      set_pins(8'h00);
      edges(3);
      expect_st("R4", 2'd2, 8'h01, 1'b1, 1'b0);
      set_pins(8'h02);
      edges(3);
      expect_st("R4", 2'd2, 8'h01, 1'b1, 1'b0);

      // R3 falling edge on line 1
      set_pins(8'h00);
      edges(3);
      expect_st("R3", 2'd2, 8'h03, 1'b1, 1'b0);

      // R5 disarmed line 5
      set_pins(8'h20);
      edges(3);
      set_pins(8'h00);
      edges(3);
      expect_st("R5", 2'd2, 8'h03, 1'b1, 1'b0);

      // R9 interrupt enable
      wr(2'd3, 8'h01);
      expect_st("R9", 2'd3, 8'h01, 1'b1, 1'b1);

      // R6 disarm drops wake, latched bits remain
      wr(2'd0, 8'h0C);
      expect_st("R6", 2'd2, 8'h03, 1'b0, 1'b0);

      // R7 clear by write
      wr(2'd2, 8'h00);
      expect_st("R7", 2'd2, 8'h00, 1'b0, 1'b0);
      wr(2'd0, 8'h0F);
      expect_st("R6", 2'd0, 8'h0F, 1'b0, 1'b0);

      set_pins(8'h01);
      edges(3);
      expect_st("R2", 2'd2, 8'h01, 1'b1, 1'b1);

      // R7 event on line 2 collides with a clearing write
      set_pins(8'h05);
      edges(1);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_wsel = 2'd2; reg_wdata = 8'h00;
      @(posedge clk); #1;
      reg_we = 1'b0;
      expect_st("R7", 2'd2, 8'h04, 1'b1, 1'b1);

      // R10 simultaneous transitions
      wr(2'd2, 8'h00);
      set_pins(8'h00);
      edges(3);
      expect_st("R10", 2'd2, 8'h00, 1'b0, 1'b0);
      set_pins(8'h05);
      edges(3);
      expect_st("R10", 2'd2, 8'h05, 1'b1, 1'b1);
      set_pins(8'h0D);
      edges(3);
      expect_st("R10", 2'd2, 8'h05, 1'b1, 1'b1);
      set_pins(8'h05);
      edges(3);
      expect_st("R10", 2'd2, 8'h0D, 1'b1, 1'b1);

      // R8 polarity change on an armed low line
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h1F);
      edges(2);
      expect_st("R8", 2'd2, 8'h00, 1'b0, 1'b0);
      wr(2'd1, 8'h1A);
      edges(1);
      expect_st("R8", 2'd2, 8'h10, 1'b1, 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule